// File: doc/BRIEF.md
# Scan-Communication Bus Bridge

The bridge sits between a processor's memory-mapped window and an internal register bus of scan-communication registers. Each 64-bit MMIO access carries a byte address. The bridge clips that address to the window and turns it into a register port address. A generation-select input chooses which of two mapping schemes is used.

A handful of port addresses are answered inside the bridge: the chip-identification register, a set of registers that read as zero, and a set of registers whose writes are dropped. Every other access goes out on the downstream register bus. There the bridge holds a request until the target acknowledges it, optionally with an error flag.

Each finished access ORs a done bit, and on a downstream error a fail bit as well, into a sticky status pair that the core can poll. Only one access is in flight at a time. The MMIO side sees ready only in the single cycle that completes its access.

Top module: `scom_bridge`

## Requirements
- R1: With `gen_new`=1 the port address is the window-masked byte address shifted right by 3.
- R2: With `gen_new`=0 the port address is ((a>>4) with its low nibble cleared) OR ((a>>3)&0xF), where a is the window-masked byte address; address bit 7 therefore has no effect.
- R3: Byte-address bits at or above `WIN_AW` are ignored.
- R4: A read of port 0xF000F returns the `CHIP_ID` parameter and issues no downstream request.
- R5: Reads of ports 0x18002, 0x1010C00, 0x1010C03, 0x1020013, 0x1020014, 0xF0033, 0xF0034, 0x90012, 0x90013, 0x90018, 0x2020007, 0x2020009, 0x202000F, 0x2013F00..0x2013F07, 0x2013028, 0x201302A, 0x2013801 and 0x2013802 return zero and issue no downstream request.
- R6: Writes to ports 0xF000F, 0x1010C00..0x1010C05, 0x1020013, 0x1020014, 0xF0033, 0xF0034, 0x90012, 0x90013, 0x90018, 0x2020007, 0x2020009, 0x202000F, 0x2013028, 0x201302A, 0x2013801 and 0x2013802 are dropped without a downstream request and complete as successful.
- R7: Every other access issues exactly one downstream request with byte address = port address << 3 and the MMIO direction. A successful read returns the downstream data.
- R8: MMIO data is big-endian. MMIO byte lane i (bits 8i+7:8i) carries register byte 7-i, in both directions, including the chip-identification value.
- R9: A downstream error sets both `status_done` and `status_fail`, and a failed read returns zero.
- R10: A successful access, local or downstream, sets `status_done` and leaves `status_fail` unchanged.
- R11: Status bits are sticky and are cleared by `status_clr`. When a clear and a completion fall in the same cycle, the old bits are dropped and the completing access's bits are kept.
- R12: One access is outstanding at a time. `mmio_ready` is high for exactly the one cycle that ends the access. `scom_req`, its address and its data are held until `scom_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_new | input | 1 | 1 selects newer-generation address mapping |
| mmio_valid | input | 1 | Access request, held until ready |
| mmio_write | input | 1 | 1 = write, 0 = read |
| mmio_addr | input | 64 | Byte address of the 8-byte access |
| mmio_wdata | input | 64 | Write data, big-endian |
| mmio_ready | output | 1 | Completion strobe, one cycle |
| mmio_rdata | output | 64 | Read data, valid with ready |
| scom_req | output | 1 | Downstream request |
| scom_we | output | 1 | Downstream write |
| scom_addr | output | WIN_AW | Downstream byte address |
| scom_wdata | output | 64 | Downstream write data |
| scom_ack | input | 1 | Downstream response |
| scom_err | input | 1 | Downstream error, valid with ack |
| scom_rdata | input | 64 | Downstream read data, valid with ack |
| status_clr | input | 1 | Clear sticky status |
| status_done | output | 1 | Sticky done bit |
| status_fail | output | 1 | Sticky fail bit |

## Verification
The bench sweeps scattered byte addresses with junk above the window in both generation modes. It predicts each downstream address arithmetically, so a mapping that keeps bit 7 in the older scheme, or that leaks high bits, shows up as a wrong forwarded address. Every listed local port is hit as a read and as a write while the downstream error is forced on. A bridge that mixes up the asymmetric read and write lists would either raise fail or return the downstream pattern instead of zero. Byte-order reversal of the chip identification and of the data is checked with non-palindromic values. The sticky-status tests cover a success after a failure, a clear on its own, and a clear that coincides with completion; a bridge that let the clear win would lose the final done bit.

// File: rtl/scom_bridge.sv
module scom_bridge #(
  parameter int          WIN_AW  = 35,
  parameter logic [63:0] CHIP_ID = 64'h0220_D049_0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_new,
  input  logic              mmio_valid,
  input  logic              mmio_write,
  input  logic [63:0]       mmio_addr,
  input  logic [63:0]       mmio_wdata,
  output logic              mmio_ready,
  output logic [63:0]       mmio_rdata,
  output logic              scom_req,
  output logic              scom_we,
  output logic [WIN_AW-1:0] scom_addr,
  output logic [63:0]       scom_wdata,
  input  logic              scom_ack,
  input  logic              scom_err,
  input  logic [63:0]       scom_rdata,
  input  logic              status_clr,
  output logic              status_done,
  output logic              status_fail
);
  localparam int PA_W = WIN_AW - 3;

  typedef enum logic [1:0] {S_IDLE, S_BUS, S_RESP} state_t;

  function automatic logic rd_local(input logic [31:0] p);
    case (p)
      32'h000F000F, 32'h00018002, 32'h01010C00, 32'h01010C03,
      32'h01020013, 32'h01020014, 32'h000F0033, 32'h000F0034,
      32'h00090012, 32'h00090013, 32'h00090018,
      32'h02020007, 32'h02020009, 32'h0202000F,
      32'h02013F00, 32'h02013F01, 32'h02013F02, 32'h02013F03,
      32'h02013F04, 32'h02013F05, 32'h02013F06, 32'h02013F07,
      32'h02013028, 32'h0201302A, 32'h02013801, 32'h02013802: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic wr_drop(input logic [31:0] p);
    case (p)
      32'h000F000F, 32'h01010C00, 32'h01010C01, 32'h01010C02,
      32'h01010C03, 32'h01010C04, 32'h01010C05,
      32'h01020013, 32'h01020014, 32'h000F0033, 32'h000F0034,
      32'h00090012, 32'h00090013, 32'h00090018,
      32'h02020007, 32'h02020009, 32'h0202000F,
      32'h02013028, 32'h0201302A, 32'h02013801, 32'h02013802: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [63:0] swap8(input logic [63:0] d);
    for (int i = 0; i < 8; i++) swap8[8*i +: 8] = d[8*(7-i) +: 8];
  endfunction

  state_t            st;
  logic              op_we, fail_q;
  logic [PA_W-1:0]   op_pa;
  logic [63:0]       op_wdata, rdata_q;

  wire [WIN_AW-1:0] win    = mmio_addr[WIN_AW-1:0];
  wire [PA_W-1:0]   pa_new = win[WIN_AW-1:3];
  wire [PA_W-1:0]   pa_old = {1'b0, win[WIN_AW-1:8], win[6:3]};
  wire [PA_W-1:0]   pa     = gen_new ? pa_new : pa_old;
  wire [31:0]       pa32   = 32'(pa);
  wire              local_hit = mmio_write ? wr_drop(pa32) : rd_local(pa32);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op_we    <= 1'b0;
      op_pa    <= '0;
      op_wdata <= '0;
      rdata_q  <= '0;
      fail_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (mmio_valid) begin
          op_we    <= mmio_write;
          op_pa    <= pa;
          op_wdata <= mmio_wdata;
          fail_q   <= 1'b0;
          rdata_q  <= (!mmio_write && pa32 == 32'h000F000F) ? CHIP_ID : 64'd0;
          st       <= local_hit ? S_RESP : S_BUS;
        end
        S_BUS: if (scom_ack) begin
          rdata_q <= scom_err ? 64'd0 : scom_rdata;
          fail_q  <= scom_err;
          st      <= S_RESP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_done <= 1'b0;
      status_fail <= 1'b0;
    end else if (st == S_RESP) begin
      status_done <= 1'b1;
      status_fail <= (status_fail & ~status_clr) | fail_q;
    end else if (status_clr) begin
      status_done <= 1'b0;
      status_fail <= 1'b0;
    end
  end

  assign mmio_ready = (st == S_RESP);
  assign mmio_rdata = swap8(rdata_q);
  assign scom_req   = (st == S_BUS);
  assign scom_we    = op_we;
  assign scom_addr  = {op_pa, 3'b000};
  assign scom_wdata = swap8(op_wdata);

  assert_fail_has_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status_fail |-> status_done);
  assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    scom_req && !scom_ack |=> scom_req && $stable(scom_addr) && $stable(scom_wdata) && $stable(scom_we));
  assert_no_ready_on_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
    scom_req |-> !mmio_ready);
  assert_ready_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mmio_ready |=> !mmio_ready);
  assert_done_after_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mmio_ready |=> status_done);
  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    status_clr && !mmio_ready |=> !status_done && !status_fail);
endmodule

// File: tb/test_scom_bridge.sv
module test_scom_bridge;
  localparam int          AW  = 35;
  localparam logic [63:0] CID = 64'h0123_4567_89AB_CDEF;

  logic clk = 0, rst_n = 0, gen_new = 1;
  logic mmio_valid = 0, mmio_write = 0, mmio_ready;
  logic [63:0] mmio_addr = 0, mmio_wdata = 0, mmio_rdata;
  logic scom_req, scom_we, scom_ack = 0, scom_err = 0;
  logic [AW-1:0] scom_addr;
  logic [63:0] scom_wdata, scom_rdata = 0;
  logic status_clr = 0, status_done, status_fail;

  scom_bridge #(.WIN_AW(AW), .CHIP_ID(CID)) i_scom_bridge (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit inj_err = 0, fwd_seen = 0, fwd_we = 0;
  int resp_dly = 0;
  logic [63:0] fwd_addr = 0, fwd_wdata = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] swp(input logic [63:0] d);
    for (int i = 0; i < 8; i++) swp[8*i +: 8] = d[8*(7-i) +: 8];
  endfunction

  function automatic logic [63:0] dn_val(input logic [63:0] a);
    return {a[31:0] ^ 32'hA5A5_5A5A, ~a[31:0]};
  endfunction

  function automatic logic [63:0] f_pa(input bit g, input logic [63:0] addr);
    logic [63:0] w = addr & ((64'd1 << AW) - 1);
    return g ? (w >> 3) : (((w >> 4) & ~64'hF) | ((w >> 3) & 64'hF));
  endfunction

  function automatic bit m_rd(input logic [63:0] p);
    return p inside {64'hF000F, 64'h18002, 64'h1010C00, 64'h1010C03, 64'h1020013,
      64'h1020014, 64'hF0033, 64'hF0034, 64'h90012, 64'h90013, 64'h90018,
      64'h2020007, 64'h2020009, 64'h202000F, [64'h2013F00:64'h2013F07],
      64'h2013028, 64'h201302A, 64'h2013801, 64'h2013802};
  endfunction

  function automatic bit m_wr(input logic [63:0] p);
    return p inside {64'hF000F, [64'h1010C00:64'h1010C05], 64'h1020013,
      64'h1020014, 64'hF0033, 64'hF0034, 64'h90012, 64'h90013, 64'h90018,
      64'h2020007, 64'h2020009, 64'h202000F,
      64'h2013028, 64'h201302A, 64'h2013801, 64'h2013802};
  endfunction

  // downstream responder
  initial forever begin
    @(negedge clk);
    if (scom_req && !scom_ack) begin
      fwd_seen = 1; fwd_addr = 64'(scom_addr); fwd_we = scom_we; fwd_wdata = scom_wdata;
      repeat (resp_dly) @(negedge clk);
      scom_rdata = dn_val(fwd_addr); scom_err = inj_err; scom_ack = 1;
      @(negedge clk);
      scom_ack = 0; scom_err = 0;
    end
  end

  task automatic access(input bit we, input logic [63:0] addr, wd, input bit g,
                        input bit clr_end, output logic [63:0] rd);
    int guard = 0;
    @(negedge clk);
    gen_new = g; mmio_valid = 1; mmio_write = we; mmio_addr = addr; mmio_wdata = wd;
    fwd_seen = 0;
    do begin @(negedge clk); guard++; end while (!mmio_ready && guard < 100);
    chk(mmio_ready, "R12 access completes", 64'(mmio_ready), 64'd1);
    rd = mmio_rdata;
    if (clr_end) status_clr = 1;
    @(negedge clk);
    mmio_valid = 0; status_clr = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); status_clr = 1;
    @(negedge clk); status_clr = 0;
  endtask

  task automatic run(input bit we, input logic [63:0] addr, wd, input bit g, input bit err);
    logic [63:0] pa = f_pa(g, addr), rd, exp;
    bit loc = we ? m_wr(pa) : m_rd(pa);
    pulse_clr();
    chk(!status_done && !status_fail, "R11 cleared", {status_done, status_fail}, 0);
    inj_err = err;
    access(we, addr, wd, g, 0, rd);
    inj_err = 0;
    chk(fwd_seen == !loc, loc ? "R4/R5/R6 local no request" : "R7 forwarded",
        64'(fwd_seen), 64'(!loc));
    if (fwd_seen && !loc) begin
      chk(fwd_addr == (pa << 3), g ? "R1 new map" : "R2 old map", fwd_addr, pa << 3);
      chk(fwd_we == we, "R7 direction", 64'(fwd_we), 64'(we));
      if (we) chk(fwd_wdata == swp(wd), "R8 write byte order", fwd_wdata, swp(wd));
    end
    if (!we) begin
      exp = loc ? (pa == 64'hF000F ? swp(CID) : 0) : (err ? 0 : swp(dn_val(pa << 3)));
      chk(rd == exp, loc ? "R4/R5 local read" : "R7/R8/R9 read data", rd, exp);
    end
    chk(status_done, "R10 done set", 64'(status_done), 1);
    chk(status_fail == (err && !loc), "R9/R10 fail bit", 64'(status_fail), 64'(err && !loc));
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL R12 watchdog expired actual=%0d expected<150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] rd;
    logic [63:0] lst[32] = '{64'hF000F, 64'h18002, 64'h1010C00, 64'h1010C01, 64'h1010C02,
      64'h1010C03, 64'h1010C04, 64'h1010C05, 64'h1010C06, 64'h1020013, 64'h1020014,
      64'hF0033, 64'hF0034, 64'h90012, 64'h90013, 64'h90018, 64'h90019, 64'h2020007,
      64'h2020009, 64'h202000F, 64'h2013F00, 64'h2013F03, 64'h2013F07, 64'h2013F08,
      64'h2013028, 64'h201302A, 64'h2013801, 64'h2013802, 64'h2013803, 64'hF000E,
      64'h0, 64'h1F000F};
    repeat (3) @(negedge clk);
    chk(!mmio_ready && !scom_req && !status_done && !status_fail, "R12 reset state",
        {mmio_ready, scom_req, status_done, status_fail}, 0);
    rst_n = 1;

    // R4 R5 R6: local lists, error forced on so any leak shows as fail
    for (int g = 0; g < 2; g++)
      for (int k = 0; k < 32; k++) begin
        logic [63:0] a = g ? (lst[k] << 3)
                           : (((lst[k] & ~64'hF) << 4) | ((lst[k] & 64'hF) << 3));
        run(0, a, 0, g[0], 1);
        run(1, a, 64'h1122_3344_5566_7788 + 64'(k), g[0], 1);
      end

    // R3: junk above the window ignored
    run(0, (64'hFFFF_FFF8 << AW) | (64'hF000F << 3), 0, 1, 0);

    // R1 R2 R7 R8 R9: address sweep in both modes
    for (int g = 0; g < 2; g++)
      for (int i = 0; i < 200; i++) begin
        resp_dly = i % 4;
        run(i[0], 64'(i) * 64'h9E37_79B9_7F4A_7C15 + 64'(i), 64'h0102_0304_0506_0700 ^ 64'(i),
            g[0], (i % 7) == 3);
      end
    resp_dly = 1;

    // R11: sticky fail survives success, then clear on its own
    pulse_clr();
    inj_err = 1; access(0, 64'h4000_0000, 0, 1, 0, rd); inj_err = 0;
    access(0, 64'h4000_0008, 0, 1, 0, rd);
    chk(status_done && status_fail, "R11 sticky fail after success",
        {status_done, status_fail}, 2'b11);
    pulse_clr();
    chk(!status_done && !status_fail, "R11 clear", {status_done, status_fail}, 0);
    // R11: clear coinciding with completion
    inj_err = 1; access(0, 64'h4000_0010, 0, 1, 0, rd); inj_err = 0;
    access(0, 64'h4000_0018, 0, 1, 1, rd);
    chk(status_done && !status_fail, "R11 clear with completion",
        {status_done, status_fail}, 2'b10);

    // R12: ready stays low while downstream is slow
    resp_dly = 20;
    @(negedge clk); gen_new = 1; mmio_valid = 1; mmio_write = 0; mmio_addr = 64'h5000_0000;
    repeat (10) @(negedge clk);
    chk(scom_req && !mmio_ready, "R12 stall during request",
        {scom_req, mmio_ready}, 2'b10);
    while (!mmio_ready) @(negedge clk);
    @(negedge clk); mmio_valid = 0;
    chk(!mmio_ready, "R12 ready single cycle", 64'(mmio_ready), 0);
    resp_dly = 0;

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule